// File: doc/BRIEF.md
# Segmented Memory Protection Checker

This block sits in the path between a processor bus and nonvolatile main memory. It decides, access by access, whether a read, a write or an instruction fetch may proceed. Two border registers cut main memory into a low, a middle and a high segment at 16-byte granularity. A fixed information region has a permission set of its own. Each of the four regions carries its own read, write and execute grants. The grant decision is combinational, so a blocked access never reaches the memory in the same cycle. A blocked write is dropped, and a blocked read or fetch returns zero to the processor.

A blocked access also sets a sticky per-region violation flag. Software clears these flags by writing ones to them. When interrupts are enabled, any violation flag raises a non-maskable interrupt request. The control register accepts a write only when the upper byte carries a password. A wrong password sets an error flag instead. A lock bit freezes the configuration until the next reset.

Top module: `seg_guard`

## Requirements
- R1: A write to the control register (select 0) takes effect only if `reg_wdata[15:8]` equals 0xA5. Any other upper byte leaves the control register unchanged and sets flag bit 4 (password error).
- R2: Control register bits: bit 0 enables checking, bit 1 locks the configuration, bit 4 enables the interrupt request. A read returns these bits in the same positions, with all other bits zero.
- R3: Border registers (select 1 and 2) hold a byte address shifted right by 4, in their low AW-4 bits. An address at or above MAIN_BASE falls in one of three segments: segment 1 if addr>>4 is below border 1; segment 2 if it is not below border 1 but is below border 2; segment 3 otherwise. With equal borders, segment 2 is empty.
- R4: The access word (select 3) holds one nibble per region: [3:0] segment 1, [7:4] segment 2, [11:8] segment 3, [15:12] information region. Within a nibble, bit 0 grants read, bit 1 grants write and bit 2 grants execute.
- R5: `acc_kind` 00 is a read, 01 a write, 10 a fetch, and 11 is treated as a read. `acc_grant` reflects the current access in the same cycle.
- R6: When an access is granted, `mem_en` is high, `mem_we` follows a write, and `acc_rdata` equals `mem_rdata`. When it is blocked, `mem_en` and `mem_we` are low and `acc_rdata` is zero.
- R7: Flag register (select 4): bit 0 segment 1, bit 1 segment 2, bit 2 segment 3, bit 3 information region, bit 4 password error. A violation sets its bit at the clock edge that ends the access. Writing 1 to a bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: With checking disabled, every access is granted and no violation flag changes.
- R9: Once the lock bit is set, writes to the control, border and access registers are ignored until reset. Flag clears still work.
- R10: `nmi_req` is high exactly while the interrupt-enable bit is set and any of flag bits 3:0 is set. A password error alone does not raise it.
- R11: Addresses below MAIN_BASE and outside the information range [INFO_BASE, INFO_BASE+INFO_SIZE) are always granted and never flag.
- R12: After reset, the control register, both borders and the flags are zero, and the access word is 0x7777.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 border 1, 2 border 2, 3 access word, 4 flags |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Byte address of the access |
| acc_kind | input | 2 | Access type: read, write, fetch |
| acc_grant | output | 1 | Access permitted |
| acc_rdata | output | 16 | Read or fetch data returned to the processor |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Data from memory |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The grant, the returned data and the memory enables are combinational. The bench drives each access just after a falling edge and samples these outputs 2 ns later, before the next rising edge. Violation flags, the interrupt request and register contents change at that rising edge. The bench therefore reads them back only after the following falling edge, one cycle after the stimulus. A sweep over every permission nibble of every region and every access kind checks each result, and an address sweep across both borders checks segment membership, all against a bench-side model of the configuration.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int AW        = 16,
  parameter int INFO_BASE = 'h1800,
  parameter int INFO_SIZE = 'h0200,
  parameter int MAIN_BASE = 'h4400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  output logic          acc_grant,
  output logic [15:0]   acc_rdata,
  output logic          mem_en,
  output logic          mem_we,
  input  logic [15:0]   mem_rdata,
  output logic          nmi_req
);
  localparam int BW = AW - 4;
  localparam logic [AW:0] INFO_LO = (AW+1)'(INFO_BASE);
  localparam logic [AW:0] INFO_HI = (AW+1)'(INFO_BASE + INFO_SIZE);
  localparam logic [AW:0] MAIN_LO = (AW+1)'(MAIN_BASE);
  localparam logic [2:0] SEL_CTL = 3'd0, SEL_B1 = 3'd1, SEL_B2 = 3'd2,
                         SEL_AM = 3'd3, SEL_FLG = 3'd4;

  logic          en, lock, nmie;
  logic [BW-1:0] b1, b2;
  logic [15:0]   sam;
  logic [4:0]    flags, flags_nxt;

  logic [AW:0]   ax;
  logic [BW-1:0] blk;
  logic          in_info, in_main;
  logic [1:0]    rgn;
  logic [3:0]    nib;
  logic          perm_ok, viol;
  logic          ctl_wr, pwd_ok, pwd_err, cfg_open;

  assign ax      = {1'b0, acc_addr};
  assign blk     = acc_addr[AW-1:4];
  assign in_info = (ax >= INFO_LO) && (ax < INFO_HI);
  assign in_main = (ax >= MAIN_LO) && !in_info;

  always_comb begin
    if (in_info)      rgn = 2'd3;
    else if (blk < b1) rgn = 2'd0;
    else if (blk < b2) rgn = 2'd1;
    else              rgn = 2'd2;
  end

  assign nib = sam[{rgn, 2'b00} +: 4];

  always_comb begin
    case (acc_kind)
      2'b01:   perm_ok = nib[1];
      2'b10:   perm_ok = nib[2];
      default: perm_ok = nib[0];
    endcase
  end

  assign viol      = acc_valid && en && (in_info || in_main) && !perm_ok;
  assign acc_grant = !viol;
  assign mem_en    = acc_valid && acc_grant;
  assign mem_we    = mem_en && (acc_kind == 2'b01);
  assign acc_rdata = acc_grant ? mem_rdata : 16'h0000;

  assign ctl_wr   = reg_we && (reg_sel == SEL_CTL);
  assign pwd_ok   = (reg_wdata[15:8] == 8'hA5);
  assign pwd_err  = ctl_wr && !pwd_ok;
  assign cfg_open = reg_we && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      lock <= 1'b0;
      nmie <= 1'b0;
      b1   <= '0;
      b2   <= '0;
      sam  <= 16'h7777;
    end else if (cfg_open) begin
      case (reg_sel)
        SEL_CTL: if (pwd_ok) begin
          en   <= reg_wdata[0];
          lock <= reg_wdata[1];
          nmie <= reg_wdata[4];
        end
        SEL_B1:  b1  <= reg_wdata[BW-1:0];
        SEL_B2:  b2  <= reg_wdata[BW-1:0];
        SEL_AM:  sam <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    flags_nxt = flags;
    if (reg_we && reg_sel == SEL_FLG) flags_nxt = flags_nxt & ~reg_wdata[4:0];
    if (viol)    flags_nxt[rgn] = 1'b1;
    if (pwd_err) flags_nxt[4]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nxt;
  end

  assign nmi_req = nmie && (|flags[3:0]);

  always_comb begin
    case (reg_sel)
      SEL_CTL: reg_rdata = {11'b0, nmie, 2'b00, lock, en};
      SEL_B1:  reg_rdata = 16'(b1);
      SEL_B2:  reg_rdata = 16'(b2);
      SEL_AM:  reg_rdata = sam;
      SEL_FLG: reg_rdata = {11'b0, flags};
      default: reg_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_sel,
  input logic [15:0]   reg_wdata,
  input logic          acc_valid,
  input logic          acc_grant,
  input logic [15:0]   acc_rdata,
  input logic          mem_en,
  input logic          mem_we,
  input logic          nmi_req,
  input logic          en,
  input logic          lock,
  input logic          nmie,
  input logic [AW-5:0] b1,
  input logic [AW-5:0] b2,
  input logic [15:0]   sam,
  input logic [4:0]    flags
);
  a_r6_block_gates_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_grant |-> (!mem_en && !mem_we && acc_rdata == 16'h0000));

  a_r8_off_grants: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> acc_grant);

  a_r9_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (lock && en == $past(en) && nmie == $past(nmie)
              && $stable(b1) && $stable(b2) && $stable(sam)));

  a_r1_bad_pwd_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 3'd0 && reg_wdata[15:8] != 8'hA5) |=> flags[4]);

  a_r7_viol_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_grant) |=> (|flags[3:0]));

  a_r10_nmi_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> nmie);
endmodule

bind seg_guard seg_guard_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_grant(acc_grant),
  .acc_rdata(acc_rdata), .mem_en(mem_en), .mem_we(mem_we),
  .nmi_req(nmi_req), .en(en), .lock(lock), .nmie(nmie),
  .b1(b1), .b2(b2), .sam(sam), .flags(flags)
);

// File: tb/seg_guard_bench.sv
module seg_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        acc_grant;
  logic [15:0] acc_rdata;
  logic        mem_en, mem_we;
  logic [15:0] mem_rdata = 16'hBEEF;
  logic        nmi_req;

  int n_chk = 0;
  int n_fail = 0;

  logic        m_en = 1'b0;
  int          m_b1 = 0, m_b2 = 0;
  logic [15:0] m_sam = 16'h7777;

  always #10 clk = ~clk;

  seg_guard u_seg_guard (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_grant(acc_grant),
    .acc_rdata(acc_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .nmi_req(nmi_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] d);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  function automatic int region(input logic [15:0] a);
    if (a >= 16'h1800 && a < 16'h1A00) return 3;
    if (a < 16'h4400) return 4;
    if (int'(a >> 4) < m_b1) return 0;
    if (int'(a >> 4) < m_b2) return 1;
    return 2;
  endfunction

  function automatic logic exp_grant(input logic [15:0] a, input logic [1:0] k);
    int r;
    r = region(a);
    if (!m_en || r == 4) return 1'b1;
    case (k)
      2'b01:   return m_sam[r*4 + 1];
      2'b10:   return m_sam[r*4 + 2];
      default: return m_sam[r*4];
    endcase
  endfunction

  task automatic access(input string tag, input logic [15:0] a, input logic [1:0] k);
    logic g;
    g = exp_grant(a, k);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k;
    #2;
    chk({tag, " R5 grant"}, acc_grant, g);
    chk({tag, " R6 rdata"}, acc_rdata, g ? mem_rdata : 16'h0);
    chk({tag, " R6 mem_en/we"}, {mem_en, mem_we}, {g, g && k == 2'b01});
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  logic [15:0] v;

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R12 ctl reset", v, 16'h0000);
    rd(3'd1, v); chk("R12 b1 reset", v, 16'h0000);
    rd(3'd2, v); chk("R12 b2 reset", v, 16'h0000);
    rd(3'd3, v); chk("R12 access word reset", v, 16'h7777);
    rd(3'd4, v); chk("R12 flags reset", v, 16'h0000);
    chk("R12 nmi reset", nmi_req, 1'b0);

    // R8: disabled, all permissions cleared, still granted
    wr(3'd3, 16'h0000); m_sam = 16'h0000;
    access("R8 off write", 16'h5000, 2'b01);
    access("R8 off info fetch", 16'h1850, 2'b10);
    rd(3'd4, v); chk("R8 no flags when off", v, 16'h0000);

    // R1 wrong password
    wr(3'd0, 16'h5A13);
    rd(3'd0, v); chk("R1 bad password ignored", v, 16'h0000);
    rd(3'd4, v); chk("R1 password error flag", v, 16'h0010);
    wr(3'd4, 16'h0010);
    rd(3'd4, v); chk("R7 W1C clears", v, 16'h0000);

    // R2 / R3 configure
    wr(3'd1, 16'h0600); m_b1 = 'h600;
    wr(3'd2, 16'h0800); m_b2 = 'h800;
    wr(3'd0, 16'hA501); m_en = 1'b1;
    rd(3'd0, v); chk("R2 ctl readback", v, 16'h0001);
    rd(3'd1, v); chk("R3 b1 readback", v, 16'h0600);
    rd(3'd4, v); chk("R1 good password no error", v, 16'h0000);

    // R4 sweep: every nibble value, every region, every kind
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 8; p++) begin
        logic [15:0] w;
        logic [15:0] ad;
        w = 16'h7777;
        w[r*4 +: 4] = 4'(p);
        wr(3'd3, w); m_sam = w;
        ad = (r == 0) ? 16'h5000 : (r == 1) ? 16'h7000 : (r == 2) ? 16'h9000 : 16'h1850;
        for (int k = 0; k < 4; k++) begin
          logic g;
          g = exp_grant(ad, 2'(k));
          access("R4 sweep", ad, 2'(k));
          rd(3'd4, v);
          chk("R7 region flag", v, g ? 16'h0 : 16'(1 << r));
          if (!g) wr(3'd4, 16'h001F);
        end
      end
    end

    // R3 border sweep with one distinct grant per segment
    wr(3'd3, 16'h0421); m_sam = 16'h0421;
    for (int a = 'h5FE0; a < 'h6020; a += 4)
      for (int k = 0; k < 3; k++) access("R3 border1", 16'(a), 2'(k));
    for (int a = 'h7FE0; a < 'h8020; a += 4)
      for (int k = 0; k < 3; k++) access("R3 border2", 16'(a), 2'(k));
    wr(3'd2, 16'h0600); m_b2 = 'h600;
    for (int a = 'h5FF0; a < 'h6010; a += 4)
      for (int k = 0; k < 3; k++) access("R3 equal borders", 16'(a), 2'(k));

    // R11 outside regions and region edges
    access("R11 below main", 16'h43FF, 2'b01);
    access("R11 main start", 16'h4400, 2'b01);
    access("R11 below info", 16'h17FF, 2'b00);
    access("R11 info start", 16'h1800, 2'b00);
    access("R11 info end", 16'h19FF, 2'b00);
    access("R11 after info", 16'h1A00, 2'b00);
    access("R11 ram fetch", 16'h2000, 2'b10);
    wr(3'd4, 16'h001F);
    access("R11 outside only", 16'h2000, 2'b01);
    rd(3'd4, v); chk("R11 no flag outside", v, 16'h0000);

    // R10 interrupt request
    wr(3'd0, 16'h3301);
    chk("R10 pwd error alone no nmi", nmi_req, 1'b0);
    wr(3'd0, 16'hA511);
    wr(3'd4, 16'h001F);
    chk("R10 nmi low when clean", nmi_req, 1'b0);
    access("R10 viol", 16'h1850, 2'b00);
    chk("R10 nmi raised", nmi_req, 1'b1);
    wr(3'd4, 16'h0008);
    chk("R10 nmi dropped on clear", nmi_req, 1'b0);
    wr(3'd0, 16'hA501);
    access("R10 viol no enable", 16'h1850, 2'b00);
    chk("R10 no nmi when disabled", nmi_req, 1'b0);
    wr(3'd4, 16'h001F);

    // R7 set wins over clear in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 16'h001F;
    acc_valid = 1'b1; acc_addr = 16'h1850; acc_kind = 2'b01;
    @(negedge clk);
    reg_we = 1'b0; acc_valid = 1'b0;
    rd(3'd4, v); chk("R7 set beats clear", v, 16'h0008);
    wr(3'd4, 16'h001F);

    // R9 lock
    wr(3'd0, 16'hA503);
    wr(3'd1, 16'h0123);
    wr(3'd3, 16'h7777);
    wr(3'd0, 16'hA500);
    rd(3'd0, v); chk("R9 ctl frozen", v, 16'h0003);
    rd(3'd1, v); chk("R9 b1 frozen", v, 16'h0600);
    rd(3'd3, v); chk("R9 access word frozen", v, 16'h0421);
    access("R9 still enforcing", 16'h1850, 2'b00);
    wr(3'd4, 16'h0008);
    rd(3'd4, v); chk("R9 flag clear while locked", v, 16'h0000);

    // R12 reset releases lock
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R12 lock cleared by reset", v, 16'h0000);
    rd(3'd3, v); chk("R12 access word after reset", v, 16'h7777);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule